// File: doc/BRIEF.md
# One-Wire Master Interrupt Controller

This block keeps the interrupt status and interrupt enable state of a one-wire bus master that is reached through a byte-wide host register port. The bus timing engine next to it sends single-cycle event pulses: reset/presence sequence finished (with a level that says whether any slave answered), transmit holding byte empty, transmit shifter empty, receive holding byte full and receive shifter full. The block latches those events and raises one interrupt line whose active level is programmable. It also decodes host reads and writes for the status, enable and data addresses and applies their side effects.

Host register addresses are a register index shifted left by `ADDR_SHIFT` bits. The indices used here are 1 for data, 2 for status and 3 for enable. The other indices belong to the engine and read as zero here. A host read of status returns the flags and withdraws the interrupt. A read of data returns the engine's received byte and clears receive-full. Software runs an event-driven loop in three steps: enable one event, start the bus operation, then service the interrupt by reading status.

Top module: `owm_irq_ctrl`

## Requirements
- R1: After reset the status and enable registers are 0, so `irq_line` is high (deasserted, active-low), `dq_drive_en` is 0 and `host_rdata` is 0.
- R2: A register is selected only when `host_addr` equals its index shifted left by `ADDR_SHIFT`. Any other address, including one with nonzero low bits, reads 0 and has no effect. `host_rdata` is registered: it shows the selected value in the cycle after the read strobe and holds until the next read.
- R3: Event pulses set latched status flags at fixed bit positions: bit0 presence sequence done, bit2 transmit holding empty, bit3 transmit shifter empty, bit4 receive holding full, bit5 receive shifter full. Bits 6 and 7 read 0.
- R4: Status bit1 is a level. On each presence-done pulse it loads `pd_no_slave` (0 means a slave answered, 1 means none answered). A status read does not clear it.
- R5: A status read returns the value from before the clear. It clears bits 0, 2, 3 and 5 and deasserts the interrupt. If an event arrives in the same cycle as the read, that event's flag stays set and it raises the interrupt again.
- R6: A data read returns `rx_byte` and clears only status bit4. A receive-full pulse in the same cycle keeps bit4 set.
- R7: The interrupt becomes pending when an event pulse arrives for an enabled bit (enable bits 0, 2, 3, 4, 5 match the status positions). It also becomes pending when an enable write turns on a bit whose flag is set. It stays pending until a status read.
- R8: Enable bit1 selects the output level: 1 gives `irq_line` equal to pending (active-high), 0 gives its inverse. Enable bit1 masks nothing, and status bit1 never raises the interrupt.
- R9: The enable register reads back bits 6:0 as written, with bit7 reading 0. Enable bit6 drives `dq_drive_en` and changes only on an enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host byte address |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| ev_pd_done | input | 1 | Presence sequence finished pulse |
| pd_no_slave | input | 1 | Presence outcome, sampled with ev_pd_done |
| ev_tx_buf_empty | input | 1 | Transmit holding byte empty pulse |
| ev_tx_shift_empty | input | 1 | Transmit shifter empty pulse |
| ev_rx_buf_full | input | 1 | Receive holding byte full pulse |
| ev_rx_shift_full | input | 1 | Receive shifter full pulse |
| rx_byte | input | 8 | Received byte held by the engine |
| irq_line | output | 1 | Interrupt output, level set by enable bit1 |
| dq_drive_en | output | 1 | Direct bus drive permission (enable bit6) |

## Verification
A wrong flag stays hidden until software reads status. It shows up one cycle after that read as a wrong `host_rdata` bit. The bench therefore reads status and enable often and compares every cycle against a model. A wrong pending state or polarity shows on `irq_line` in the cycle right after the triggering event, enable write or status read. The same-cycle collisions are the cases most likely to stay hidden: an event arriving with a status read, or receive-full arriving with a data read. They are driven directly so that a lost flag appears at the next read.

// File: rtl/owm_irq_pkg.sv
package owm_irq_pkg;

  localparam int REG_W = 8;

  // register indices (before the address shift)
  localparam int IDX_DATA = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_EN   = 3;
  localparam int NUM_SEL  = 3;

  // status bit positions
  localparam int B_PD   = 0;
  localparam int B_PRES = 1;
  localparam int B_TBE  = 2;
  localparam int B_TSRE = 3;
  localparam int B_RBF  = 4;
  localparam int B_RSRF = 5;

  // enable bit positions that are not event masks
  localparam int E_POL = 1;
  localparam int E_DQ  = 6;

  localparam logic [REG_W-1:0] EVENT_MASK  = 8'b0011_1101;
  localparam logic [REG_W-1:0] STAT_CLR    = 8'b0010_1101;
  localparam logic [REG_W-1:0] EN_KEEP     = 8'b0111_1111;

  typedef enum logic [1:0] {SEL_DATA = 2'd0, SEL_STAT = 2'd1, SEL_EN = 2'd2} sel_e;

  // byte offset of a register index
  function automatic int reg_offset(input int idx, input int shift);
    return idx << shift;
  endfunction

  // pending arms on an enabled event, or on an enable write exposing a set flag
  function automatic logic arm_calc(input logic [REG_W-1:0] set_vec,
                                    input logic [REG_W-1:0] en_q,
                                    input logic             en_wr,
                                    input logic [REG_W-1:0] wdata,
                                    input logic [REG_W-1:0] flags_q);
    logic ev_hit, wr_hit;
    ev_hit = |(set_vec & en_q & EVENT_MASK);
    wr_hit = en_wr & (|((flags_q | set_vec) & wdata & EVENT_MASK));
    return ev_hit | wr_hit;
  endfunction

  // clear vector produced by host reads
  function automatic logic [REG_W-1:0] clr_calc(input logic stat_rd, input logic data_rd);
    logic [REG_W-1:0] c;
    c = stat_rd ? STAT_CLR : '0;
    if (data_rd) c[B_RBF] = 1'b1;
    return c;
  endfunction

  // pin level from pending state and polarity bit
  function automatic logic pin_level(input logic pending, input logic active_high);
    return active_high ? pending : ~pending;
  endfunction

endpackage

// File: rtl/owm_irq_decode.sv
module owm_irq_decode #(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               rd,
  input  logic                               wr,
  output logic [owm_irq_pkg::NUM_SEL-1:0]    sel,
  output logic                               stat_rd,
  output logic                               data_rd,
  output logic                               en_wr
);
  import owm_irq_pkg::*;

  // select g corresponds to register index g+1 (data, status, enable)
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    localparam int OFFS = reg_offset(g + 1, ADDR_SHIFT);
    assign sel[g] = (addr == ADDR_W'(OFFS));
  end

  assign stat_rd = rd & sel[SEL_STAT];
  assign data_rd = rd & sel[SEL_DATA];
  assign en_wr   = wr & sel[SEL_EN];

endmodule

// File: rtl/owm_irq_flags.sv
module owm_irq_flags (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [owm_irq_pkg::REG_W-1:0]  set_vec,
  input  logic                           pd_done,
  input  logic                           pd_no_slave,
  input  logic [owm_irq_pkg::REG_W-1:0]  clr_vec,
  output logic [owm_irq_pkg::REG_W-1:0]  flags
);
  import owm_irq_pkg::*;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (EVENT_MASK[b]) begin : g_event
      // a set in the same cycle wins over a clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     flags[b] <= 1'b0;
        else if (set_vec[b])            flags[b] <= 1'b1;
        else if (clr_vec[b])            flags[b] <= 1'b0;
      end
    end else if (b == B_PRES) begin : g_pres
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flags[b] <= 1'b0;
        else if (pd_done) flags[b] <= pd_no_slave;
      end
    end else begin : g_zero
      assign flags[b] = 1'b0;
    end
  end

endmodule

// File: rtl/owm_irq_enable.sv
module owm_irq_enable (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en_wr,
  input  logic [owm_irq_pkg::REG_W-1:0]  wdata,
  output logic [owm_irq_pkg::REG_W-1:0]  en_q
);
  import owm_irq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wdata & EN_KEEP;
  end

endmodule

// File: rtl/owm_irq_out.sv
module owm_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic stat_rd,
  input  logic active_high,
  output logic pending,
  output logic irq_line
);
  import owm_irq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (arm)     pending <= 1'b1;
    else if (stat_rd) pending <= 1'b0;
  end

  assign irq_line = pin_level(pending, active_high);

endmodule

// File: rtl/owm_irq_ctrl.sv
module owm_irq_ctrl #(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              ev_pd_done,
  input  logic              pd_no_slave,
  input  logic              ev_tx_buf_empty,
  input  logic              ev_tx_shift_empty,
  input  logic              ev_rx_buf_full,
  input  logic              ev_rx_shift_full,
  input  logic [7:0]        rx_byte,
  output logic              irq_line,
  output logic              dq_drive_en
);
  import owm_irq_pkg::*;

  logic [NUM_SEL-1:0] sel;
  logic               stat_rd, data_rd, en_wr;
  logic [REG_W-1:0]   set_vec, clr_vec, flags, en_q;
  logic [REG_W-1:0]   rd_mux;
  logic               arm, pending;

  owm_irq_decode #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) i_decode (
    .addr(host_addr), .rd(host_rd), .wr(host_wr),
    .sel(sel), .stat_rd(stat_rd), .data_rd(data_rd), .en_wr(en_wr)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_PD]   = ev_pd_done;
    set_vec[B_TBE]  = ev_tx_buf_empty;
    set_vec[B_TSRE] = ev_tx_shift_empty;
    set_vec[B_RBF]  = ev_rx_buf_full;
    set_vec[B_RSRF] = ev_rx_shift_full;
  end

  assign clr_vec = clr_calc(stat_rd, data_rd);

  owm_irq_flags i_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .pd_done(ev_pd_done),
    .pd_no_slave(pd_no_slave), .clr_vec(clr_vec), .flags(flags)
  );

  owm_irq_enable i_enable (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .wdata(host_wdata), .en_q(en_q)
  );

  assign arm = arm_calc(set_vec, en_q, en_wr, host_wdata, flags);

  owm_irq_out i_out (
    .clk(clk), .rst_n(rst_n), .arm(arm), .stat_rd(stat_rd),
    .active_high(en_q[E_POL]), .pending(pending), .irq_line(irq_line)
  );

  assign dq_drive_en = en_q[E_DQ];

  always_comb begin
    rd_mux = '0;
    if (sel[SEL_STAT])      rd_mux = flags;
    else if (sel[SEL_EN])   rd_mux = en_q;
    else if (sel[SEL_DATA]) rd_mux = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

endmodule

// File: rtl/owm_irq_chk.sv
module owm_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_rd,
  input logic       data_rd,
  input logic       en_wr,
  input logic       arm,
  input logic       pending,
  input logic [7:0] flags,
  input logic [7:0] set_vec,
  input logic       pd_done,
  input logic       dq_drive_en
);

  assert_stat_read_drops_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !arm) |=> !pending);

  assert_data_read_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !set_vec[4]) |=> !flags[4]);

  assert_presence_level_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_done |=> (flags[1] == $past(flags[1])));

  assert_event_latches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[3] |=> flags[3]);

  assert_pending_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !$past(pending)) |-> $past(arm));

  assert_drive_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(dq_drive_en));

endmodule

bind owm_irq_ctrl owm_irq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd), .en_wr(en_wr),
  .arm(arm), .pending(pending), .flags(flags), .set_vec(set_vec),
  .pd_done(ev_pd_done), .dq_drive_en(dq_drive_en)
);

// File: tb/test_owm_irq_ctrl.sv
module test_owm_irq_ctrl;
  localparam int AW = 8;
  localparam int SH = 2;
  localparam logic [7:0] A_DATA = 8'd1 << SH;
  localparam logic [7:0] A_STAT = 8'd2 << SH;
  localparam logic [7:0] A_EN   = 8'd3 << SH;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] host_addr = 0;
  logic host_rd = 0, host_wr = 0;
  logic [7:0] host_wdata = 0, host_rdata, rx_byte = 0;
  logic [7:0] ev = 0;
  logic pd_no_slave = 0;
  logic irq_line, dq_drive_en;

  always #2 clk = ~clk;

  owm_irq_ctrl #(.ADDR_W(AW), .ADDR_SHIFT(SH)) i_owm_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ev_pd_done(ev[0]), .pd_no_slave(pd_no_slave), .ev_tx_buf_empty(ev[2]),
    .ev_tx_shift_empty(ev[3]), .ev_rx_buf_full(ev[4]), .ev_rx_shift_full(ev[5]),
    .rx_byte(rx_byte), .irq_line(irq_line), .dq_drive_en(dq_drive_en)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R3";

  // bench model state
  logic [7:0] m_stat = 0, m_en = 0, m_rdata = 0;
  logic       m_pend = 0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // read value as the requirements define it
  function automatic logic [7:0] view(input logic [7:0] a, input logic [7:0] rx);
    if (a == A_STAT) return m_stat;
    if (a == A_EN)   return m_en;
    if (a == A_DATA) return rx;
    return 8'h00;
  endfunction

  // one bus cycle: drive, update model, sample after the edge
  task automatic step(input logic rd, input logic wr, input logic [7:0] a,
                      input logic [7:0] wd, input logic [7:0] e,
                      input logic ns, input logic [7:0] rx);
    logic [7:0] evm, nstat, nen;
    logic srd, drd, ewr, trig;
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
    ev = e & 8'h3D; pd_no_slave = ns; rx_byte = rx;
    evm  = e & 8'h3D;
    srd  = rd && a == A_STAT;
    drd  = rd && a == A_DATA;
    ewr  = wr && a == A_EN;
    trig = 1'b0;
    for (int b = 0; b < 8; b++) begin
      if (evm[b] && m_en[b]) trig = 1'b1;
      if (ewr && wd[b] && (m_stat[b] || evm[b]) && (8'h3D >> b) % 2 == 1) trig = 1'b1;
    end
    if (rd) m_rdata = view(a, rx);
    nstat = m_stat;
    if (srd) nstat = nstat & 8'b1101_0010;
    if (drd) nstat[4] = 1'b0;
    nstat = nstat | evm;
    if (e[0]) nstat[1] = ns;
    nen = ewr ? {1'b0, wd[6:0]} : m_en;
    m_pend = trig ? 1'b1 : (srd ? 1'b0 : m_pend);
    m_stat = nstat; m_en = nen;
    @(posedge clk); #1;
    check(tag, host_rdata, m_rdata);
    check((tag == "R3") ? "R7" : tag, {7'd0, irq_line}, {7'd0, m_en[1] ? m_pend : ~m_pend});
    check((tag == "R3") ? "R9" : tag, {7'd0, dq_drive_en}, {7'd0, m_en[6]});
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", {7'd0, irq_line}, 8'd1);
    check("R1", {7'd0, dq_drive_en}, 8'd0);
    check("R1", host_rdata, 8'd0);
    @(negedge clk); rst_n = 1;
    tag = "R1"; step(1, 0, A_STAT, 0, 0, 0, 0);
    check("R1", host_rdata, 8'h00);
    tag = "R1"; step(1, 0, A_EN, 0, 0, 0, 0);

    // R3 events latch, R2 misaligned address reads 0 and has no effect
    tag = "R3"; step(0, 0, 0, 0, 8'h3D, 1, 0);
    tag = "R2"; step(1, 0, A_STAT + 8'd1, 0, 0, 0, 8'h5A);
    check("R2", host_rdata, 8'h00);
    tag = "R2"; step(0, 1, A_EN + 8'd2, 8'h7F, 0, 0, 0);
    check("R2", {7'd0, irq_line}, 8'd1);
    tag = "R3"; step(1, 0, A_STAT, 0, 0, 0, 0);
    check("R3", host_rdata, 8'h3F);
    // R4 presence level survives status read; clear of 0,2,3,5 (R5)
    tag = "R4"; step(1, 0, A_STAT, 0, 0, 0, 0);
    check("R4", host_rdata, 8'h12);
    // R6 data read clears bit4 and returns rx byte
    tag = "R6"; step(1, 0, A_DATA, 0, 0, 0, 8'hC3);
    check("R6", host_rdata, 8'hC3);
    tag = "R6"; step(1, 0, A_STAT, 0, 0, 0, 0);
    check("R6", host_rdata, 8'h02);
    // R4 slave answered
    tag = "R4"; step(0, 0, 0, 0, 8'h01, 0, 0);
    tag = "R4"; step(1, 0, A_STAT, 0, 0, 0, 0);
    check("R4", host_rdata, 8'h01);
    // R7 enabled event raises interrupt (active-low default)
    tag = "R7"; step(0, 1, A_EN, 8'h08, 0, 0, 0);
    tag = "R7"; step(0, 0, 0, 0, 8'h08, 0, 0);
    check("R7", {7'd0, irq_line}, 8'd0);
    tag = "R5"; step(1, 0, A_STAT, 0, 0, 0, 0);
    check("R5", {7'd0, irq_line}, 8'd1);
    // R5 event in same cycle as status read re-raises
    tag = "R5"; step(0, 0, 0, 0, 8'h08, 0, 0);
    tag = "R5"; step(1, 0, A_STAT, 0, 0, 8'h08, 0);
    tag = "R5"; step(0, 0, 0, 0, 8'h08, 0, 0);
    tag = "R5"; step(1, 0, A_STAT, 0, 8'h08, 0, 0);
    check("R5", {7'd0, irq_line}, 8'd0);
    tag = "R5"; step(1, 0, A_STAT, 0, 0, 0, 0);
    check("R5", host_rdata, 8'h08);
    // R6 receive-full arriving with a data read stays set
    tag = "R6"; step(1, 0, A_DATA, 0, 8'h10, 0, 8'h11);
    tag = "R6"; step(1, 0, A_STAT, 0, 0, 0, 0);
    check("R6", host_rdata, 8'h10);
    // R8 polarity bit only, presence bit never interrupts
    tag = "R8"; step(0, 1, A_EN, 8'h02, 0, 0, 0);
    check("R8", {7'd0, irq_line}, 8'd0);
    tag = "R8"; step(0, 0, 0, 0, 8'h00, 0, 0);
    tag = "R8"; step(1, 0, A_STAT, 0, 0, 0, 0);
    tag = "R8"; step(0, 0, 0, 0, 8'h01, 1, 0);
    check("R8", {7'd0, irq_line}, 8'd0);
    // R7 enable write exposing set flag, active-high
    tag = "R7"; step(0, 1, A_EN, 8'h03, 0, 0, 0);
    check("R7", {7'd0, irq_line}, 8'd1);
    // R9 readback with bit7 dropped, drive bit
    tag = "R9"; step(0, 1, A_EN, 8'hC0, 0, 0, 0);
    check("R9", {7'd0, dq_drive_en}, 8'd1);
    tag = "R9"; step(1, 0, A_EN, 0, 0, 0, 0);
    check("R9", host_rdata, 8'h40);

    // random mix
    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      int op; logic [7:0] a, e;
      op = $urandom % 4;
      case ($urandom % 5)
        0: a = A_DATA; 1, 2: a = A_STAT; 3: a = A_EN; default: a = 8'($urandom);
      endcase
      e = 0;
      for (int b = 0; b < 6; b++) if ($urandom % 7 == 0) e[b] = 1'b1;
      step(op == 1, op == 2 && ($urandom % 3 == 0), a, 8'($urandom), e,
           1'($urandom), 8'($urandom));
    end
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule